// File: doc/BRIEF.md
# Posted Write Buffer for a PCI Target Path

This block sits between a simplified PCI target write path and an internal memory port. Each PCI data phase offered during a memory write burst is taken into an eight-word (32-byte) queue in the same cycle it is offered, provided there is room. The PCI transaction can therefore complete while the internal controller is still waiting for memory. The queue drains in arrival order as separate single-beat writes. Each beat carries the address, data and byte enables that the word was stored with.

Read ordering is kept with a two-bit request and grant pair, one bit for each read direction. A read is granted only after every posted write has left the queue. While a read waits, no new burst is admitted. If an internal conflict arises during a burst, the rest of that burst is refused with a target abort. Words accepted before the abort still drain. A sticky status bit records the abort until software writes a one to clear it.

The controller has five states. IDLE is the state between bursts. BURST holds while a burst continues. DROP discards the remainder of an aborted burst. FLUSH waits for the queue to empty. GRANT holds the read grant. The transitions are:

- IDLE to FLUSH when any read request is seen.
- IDLE to BURST when a first phase without the last marker is accepted.
- BURST to IDLE when the last phase is accepted, or when an abort falls on the last phase.
- BURST to DROP when an abort falls on any other phase.
- DROP to IDLE when an offered phase carries the last marker.
- FLUSH to GRANT when the queue is empty.
- GRANT to IDLE when all read requests have dropped.

Top module: `pci_post_wbuf`

## Requirements
- R1: After reset, iw_req, rd_grant, pw_abort and ta_flag are all low, the controller is in IDLE, and the queue is empty.
- R2: A phase is accepted in the cycle where pw_valid and pw_ready are both high, with no dependence on iw_ack. The queue holds 8 words of 32 bits, which is 32 bytes.
- R3: Each accepted phase leaves the block as exactly one single-beat write, in acceptance order, with unchanged address, data and active-high byte enables (bit n enables byte lane n). iw_req rises in the cycle after the first word enters an empty queue.
- R4: Once iw_req is high and iw_ack is low, iw_req stays high with iw_addr, iw_data and iw_be stable. Each cycle with iw_req and iw_ack both high retires exactly one word.
- R5: With 8 words held, pw_ready is low. It returns high in the cycle after a word retires, unless the state or a conflict forbids it.
- R6: rd_req bit 0 asks for a local-to-PCI read and bit 1 asks for a PCI-to-local read. A request seen in IDLE moves the controller to FLUSH, and pw_ready is low from that cycle on. GRANT is entered only once the queue is empty, and there rd_grant equals rd_req. The controller returns to IDLE when rd_req is zero.
- R7: In BURST, an offered phase with mem_conflict high raises pw_abort in that cycle and is not accepted. Later phases of the burst are refused, with pw_ready low, up to and including the phase marked pw_last.
- R8: ta_flag goes high in the cycle after pw_abort and stays high.
- R9: ta_flag is cleared, in the next cycle, only by st_wr high with st_wdata high. st_wr with st_wdata low has no effect. A new abort in the same cycle wins over a clear.
- R10: An accepted phase marked pw_last ends the burst, and the controller returns to IDLE. In IDLE, pw_ready is high whenever rd_req is zero and the queue is not full.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| pw_valid | input | 1 | PCI write data phase offered |
| pw_last | input | 1 | Offered phase is the last of the burst |
| pw_addr | input | AW | Word address of the phase |
| pw_data | input | DW | Write data |
| pw_be | input | DW/8 | Byte enables, active high |
| pw_ready | output | 1 | Phase accepted this cycle when pw_valid is high |
| pw_abort | output | 1 | Target abort for this phase |
| mem_conflict | input | 1 | Internal conflict, aborts a running burst |
| iw_req | output | 1 | Internal single-beat write request |
| iw_addr | output | AW | Internal write address |
| iw_data | output | DW | Internal write data |
| iw_be | output | DW/8 | Internal byte enables |
| iw_ack | input | 1 | Internal write completed |
| rd_req | input | 2 | Read requests: bit 0 local-to-PCI, bit 1 PCI-to-local |
| rd_grant | output | 2 | Read may complete, per direction |
| st_wr | input | 1 | Status register write strobe |
| st_wdata | input | 1 | Write data for the abort bit (1 clears) |
| ta_flag | output | 1 | Sticky target-abort-signalled bit |

## Verification
pw_ready and pw_abort respond within the same cycle, because they are combinational from the registered state, the queue count and mem_conflict. A queue write shows up on iw_req one cycle later. ta_flag follows an abort or a clear by one cycle. A grant appears one cycle after the controller reaches FLUSH with an empty queue. The bench drives every input just after the falling edge and waits one nanosecond. It then compares outputs against a bench model, which advances its own state, count and flag only at the rising edge, so each expected value is due in exactly the sampled cycle.

// File: rtl/pwb_pkg.sv
package pwb_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_BURST,
        ST_DROP,
        ST_FLUSH,
        ST_GRANT
    } pwb_state_e;

    localparam int RD_DIRS = 2;
endpackage

// File: rtl/pwb_fifo.sv
module pwb_fifo #(
    parameter int AW    = 32,
    parameter int DW    = 32,
    parameter int DEPTH = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            push,
    input  logic [AW-1:0]   in_addr,
    input  logic [DW-1:0]   in_data,
    input  logic [DW/8-1:0] in_be,
    input  logic            pop,
    output logic [AW-1:0]   hd_addr,
    output logic [DW-1:0]   hd_data,
    output logic [DW/8-1:0] hd_be,
    output logic            empty,
    output logic            full
);
    localparam int BEW = DW / 8;
    localparam int EW  = AW + DW + BEW;
    localparam int PW  = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam logic [PW-1:0] LASTP = PW'(DEPTH - 1);
    localparam logic [PW:0]   FULLC = (PW + 1)'(DEPTH);

    logic [EW-1:0] slot [DEPTH];
    logic [PW-1:0] wp, rp;
    logic [PW:0]   cnt;

    always_ff @(posedge clk) begin
        if (push) slot[wp] <= {in_addr, in_data, in_be};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wp  <= '0;
            rp  <= '0;
            cnt <= '0;
        end else begin
            if (push) wp <= (wp == LASTP) ? '0 : wp + 1'b1;
            if (pop)  rp <= (rp == LASTP) ? '0 : rp + 1'b1;
            unique case ({push, pop})
                2'b10:   cnt <= cnt + 1'b1;
                2'b01:   cnt <= cnt - 1'b1;
                default: cnt <= cnt;
            endcase
        end
    end

    assign {hd_addr, hd_data, hd_be} = slot[rp];
    assign empty = (cnt == '0);
    assign full  = (cnt == FULLC);

    // R5: the controller never writes into a full queue
    p_no_overflow_r5: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> !full);
    // R4: a beat is retired only when one is held
    p_no_underflow_r4: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> !empty);
endmodule

// File: rtl/pwb_ctrl.sv
module pwb_ctrl
    import pwb_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               pw_valid,
    input  logic               pw_last,
    input  logic               mem_conflict,
    input  logic               full,
    input  logic               empty,
    input  logic [RD_DIRS-1:0] rd_req,
    output logic               pw_ready,
    output logic               pw_abort,
    output logic               push,
    output logic [RD_DIRS-1:0] rd_grant
);
    pwb_state_e state, state_nx;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: begin
                if (|rd_req)
                    state_nx = ST_FLUSH;
                else if (pw_valid && !full && !pw_last)
                    state_nx = ST_BURST;
            end
            ST_BURST: begin
                if (pw_valid && mem_conflict)
                    state_nx = pw_last ? ST_IDLE : ST_DROP;
                else if (pw_valid && !full && pw_last)
                    state_nx = ST_IDLE;
            end
            ST_DROP: begin
                if (pw_valid && pw_last) state_nx = ST_IDLE;
            end
            ST_FLUSH: begin
                if (empty) state_nx = ST_GRANT;
            end
            ST_GRANT: begin
                if (!(|rd_req)) state_nx = ST_IDLE;
            end
            default: state_nx = ST_IDLE;
        endcase
    end

    always_comb begin
        pw_ready = 1'b0;
        pw_abort = 1'b0;
        rd_grant = '0;
        unique case (state)
            ST_IDLE:  pw_ready = !(|rd_req) && !full;
            ST_BURST: begin
                pw_ready = !full && !mem_conflict;
                pw_abort = pw_valid && mem_conflict;
            end
            ST_GRANT: rd_grant = rd_req;
            default: ;
        endcase
        push = pw_valid && pw_ready;
    end

    // R5: a full queue stalls the PCI side
    p_full_stall_r5: assert property (@(posedge clk) disable iff (!rst_n)
        full |-> !pw_ready);
    // R6: no read completes while a posted write remains
    p_grant_empty_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (|rd_grant) |-> empty);
    // R7: an aborted phase is never stored
    p_abort_refuse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        pw_abort |-> !push);
    // R7: the tail of an aborted burst is refused
    p_drop_refuse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_DROP) |-> !pw_ready);
    // R10: an accepted last phase returns to idle
    p_last_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (push && pw_last) |=> (state == ST_IDLE));
endmodule

// File: rtl/pwb_status.sv
module pwb_status (
    input  logic clk,
    input  logic rst_n,
    input  logic set,
    input  logic st_wr,
    input  logic st_wdata,
    output logic ta_flag
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                 ta_flag <= 1'b0;
        else if (set)               ta_flag <= 1'b1;
        else if (st_wr && st_wdata) ta_flag <= 1'b0;
    end

    // R8: an abort always leaves the bit set
    p_abort_sets_r8: assert property (@(posedge clk) disable iff (!rst_n)
        set |=> ta_flag);
    // R9: only a write of one clears the bit
    p_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (ta_flag && !(st_wr && st_wdata)) |=> ta_flag);
    // R9: a clear without a competing abort takes effect
    p_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (st_wr && st_wdata && !set) |=> !ta_flag);
endmodule

// File: rtl/pci_post_wbuf.sv
module pci_post_wbuf #(
    parameter int AW        = 32,
    parameter int DW        = 32,
    parameter int BUF_BYTES = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            pw_valid,
    input  logic            pw_last,
    input  logic [AW-1:0]   pw_addr,
    input  logic [DW-1:0]   pw_data,
    input  logic [DW/8-1:0] pw_be,
    output logic            pw_ready,
    output logic            pw_abort,
    input  logic            mem_conflict,
    output logic            iw_req,
    output logic [AW-1:0]   iw_addr,
    output logic [DW-1:0]   iw_data,
    output logic [DW/8-1:0] iw_be,
    input  logic            iw_ack,
    input  logic [1:0]      rd_req,
    output logic [1:0]      rd_grant,
    input  logic            st_wr,
    input  logic            st_wdata,
    output logic            ta_flag
);
    localparam int BEW   = DW / 8;
    localparam int DEPTH = BUF_BYTES / BEW;

    logic push, pop, empty, full;

    pwb_ctrl u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .pw_valid     (pw_valid),
        .pw_last      (pw_last),
        .mem_conflict (mem_conflict),
        .full         (full),
        .empty        (empty),
        .rd_req       (rd_req),
        .pw_ready     (pw_ready),
        .pw_abort     (pw_abort),
        .push         (push),
        .rd_grant     (rd_grant)
    );

    pwb_fifo #(.AW(AW), .DW(DW), .DEPTH(DEPTH)) u_fifo (
        .clk     (clk),
        .rst_n   (rst_n),
        .push    (push),
        .in_addr (pw_addr),
        .in_data (pw_data),
        .in_be   (pw_be),
        .pop     (pop),
        .hd_addr (iw_addr),
        .hd_data (iw_data),
        .hd_be   (iw_be),
        .empty   (empty),
        .full    (full)
    );

    pwb_status u_stat (
        .clk      (clk),
        .rst_n    (rst_n),
        .set      (pw_abort),
        .st_wr    (st_wr),
        .st_wdata (st_wdata),
        .ta_flag  (ta_flag)
    );

    assign iw_req = !empty;
    assign pop    = iw_req && iw_ack;

    // R4: a pending beat holds its request and payload until acknowledged
    p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (iw_req && !iw_ack) |=> (iw_req && $stable(iw_addr) && $stable(iw_data) && $stable(iw_be)));
    // R6: a grant never coexists with an outstanding internal write
    p_grant_drained_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (|rd_grant) |-> !iw_req);
endmodule

// File: tb/pci_post_wbuf_test.sv
`timescale 1ns/1ps
module pci_post_wbuf_test;
    localparam int DEPTH = 8;
    localparam int M_IDLE = 0, M_BURST = 1, M_DROP = 2, M_FLUSH = 3, M_GRANT = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        pw_valid = 1'b0, pw_last = 1'b0, mem_conflict = 1'b0;
    logic [31:0] pw_addr = '0, pw_data = '0;
    logic [3:0]  pw_be = '0;
    logic        pw_ready, pw_abort, iw_req;
    logic [31:0] iw_addr, iw_data;
    logic [3:0]  iw_be;
    logic        iw_ack = 1'b0;
    logic [1:0]  rd_req = '0, rd_grant;
    logic        st_wr = 1'b0, st_wdata = 1'b0, ta_flag;

    int checks = 0, errors = 0;
    bit done = 0;

    int          mst = M_IDLE;
    bit          mta = 0;
    bit          prev_hold = 0;
    logic [67:0] mq[$];

    always #2 clk = ~clk;

    pci_post_wbuf uut (
        .clk(clk), .rst_n(rst_n),
        .pw_valid(pw_valid), .pw_last(pw_last), .pw_addr(pw_addr), .pw_data(pw_data),
        .pw_be(pw_be), .pw_ready(pw_ready), .pw_abort(pw_abort),
        .mem_conflict(mem_conflict),
        .iw_req(iw_req), .iw_addr(iw_addr), .iw_data(iw_data), .iw_be(iw_be), .iw_ack(iw_ack),
        .rd_req(rd_req), .rd_grant(rd_grant),
        .st_wr(st_wr), .st_wdata(st_wdata), .ta_flag(ta_flag)
    );

    function automatic bit exp_ready(int st, int cnt, logic [1:0] r, bit c);
        case (st)
            M_IDLE:  return (r == 2'b00) && (cnt < DEPTH);
            M_BURST: return (cnt < DEPTH) && !c;
            default: return 1'b0;
        endcase
    endfunction

    function automatic int next_st(int st, bit v, bit l, bit c, bit acc, logic [1:0] r, bit emp);
        case (st)
            M_IDLE:  return (r != 2'b00) ? M_FLUSH : ((acc && !l) ? M_BURST : M_IDLE);
            M_BURST: begin
                if (v && c) return l ? M_IDLE : M_DROP;
                return (acc && l) ? M_IDLE : M_BURST;
            end
            M_DROP:  return (v && l) ? M_IDLE : M_DROP;
            M_FLUSH: return emp ? M_GRANT : M_FLUSH;
            default: return (r == 2'b00) ? M_IDLE : M_GRANT;
        endcase
    endfunction

    task automatic chk(string tag, logic [67:0] act, logic [67:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic step(bit v, bit l, bit c, bit a, logic [1:0] r, bit sw, bit sd);
        int  cnt;
        bit  er, ea;
        logic [1:0] eg;
        string rtag;
        @(negedge clk);
        pw_valid = v; pw_last = l; mem_conflict = c; iw_ack = a;
        rd_req = r; st_wr = sw; st_wdata = sd;
        pw_addr = {$urandom() & 32'hFFFF_FFFC};
        pw_data = $urandom();
        pw_be   = 4'($urandom());
        #1;
        cnt = mq.size();
        er  = exp_ready(mst, cnt, r, c);
        ea  = (mst == M_BURST) && v && c;
        eg  = (mst == M_GRANT) ? r : 2'b00;
        if (cnt == DEPTH)                          rtag = "R5";
        else if (mst == M_FLUSH || mst == M_GRANT) rtag = "R6";
        else if (mst == M_DROP)                    rtag = "R7";
        else if (mst == M_IDLE && r != 2'b00)      rtag = "R6";
        else if (mst == M_IDLE)                    rtag = "R10";
        else                                       rtag = "R2";
        chk({rtag, " pw_ready"}, 68'(pw_ready), 68'(er));
        chk("R7 pw_abort", 68'(pw_abort), 68'(ea));
        chk("R3 iw_req", 68'(iw_req), 68'(cnt > 0));
        if (cnt > 0) begin
            if (prev_hold) chk("R4 held beat", {iw_addr, iw_data, iw_be}, mq[0]);
            else           chk("R3 beat payload", {iw_addr, iw_data, iw_be}, mq[0]);
        end
        chk("R6 rd_grant", 68'(rd_grant), 68'(eg));
        chk(mta ? "R9 ta_flag" : "R8 ta_flag", 68'(ta_flag), 68'(mta));
        prev_hold = (cnt > 0) && !a;
        mst = next_st(mst, v, l, c, er && v, r, cnt == 0);
        if (cnt > 0 && a) void'(mq.pop_front());
        if (v && er) mq.push_back({pw_addr, pw_data, pw_be});
        if (ea) mta = 1;
        else if (sw && sd) mta = 0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [1:0] r;
        void'($urandom(32'd20240611));
        repeat (3) @(posedge clk);
        #1;
        // R1: reset state
        chk("R1 iw_req", 68'(iw_req), 68'd0);
        chk("R1 rd_grant", 68'(rd_grant), 68'd0);
        chk("R1 ta_flag", 68'(ta_flag), 68'd0);
        chk("R1 pw_abort", 68'(pw_abort), 68'd0);
        @(negedge clk);
        rst_n = 1'b1;

        // R5, R2: fill beyond capacity with no acknowledge
        for (int i = 0; i < 12; i++) step(1, i == 11, 0, 0, 2'b00, 0, 0);
        for (int i = 0; i < 20 && mst != M_IDLE; i++) step(1, 1, 0, 1, 2'b00, 0, 0);
        for (int i = 0; i < 12; i++) step(0, 0, 0, 1, 2'b00, 0, 0);

        // R7, R8: abort in mid-burst, tail dropped
        step(1, 0, 0, 1, 2'b00, 0, 0);
        step(1, 0, 0, 1, 2'b00, 0, 0);
        step(1, 0, 1, 1, 2'b00, 0, 0);
        step(1, 0, 0, 1, 2'b00, 0, 0);
        step(1, 1, 0, 1, 2'b00, 0, 0);
        for (int i = 0; i < 5; i++) step(0, 0, 0, 1, 2'b00, 0, 0);

        // R9: write of zero keeps the flag, write of one clears it
        step(0, 0, 0, 1, 2'b00, 1, 0);
        step(0, 0, 0, 1, 2'b00, 0, 0);
        step(0, 0, 0, 1, 2'b00, 1, 1);
        step(0, 0, 0, 1, 2'b00, 0, 0);

        // R6: both read directions wait for the flush
        for (int d = 1; d < 3; d++) begin
            step(1, 0, 0, 0, 2'b00, 0, 0);
            step(1, 0, 0, 0, 2'b00, 0, 0);
            step(1, 1, 0, 0, 2'b00, 0, 0);
            for (int i = 0; i < 4; i++) step(1, 1, 0, 0, 2'(d), 0, 0);
            for (int i = 0; i < 8; i++) step(1, 1, 0, 1, 2'(d), 0, 0);
            step(0, 0, 0, 1, 2'b00, 0, 0);
            step(0, 0, 0, 1, 2'b00, 0, 0);
        end

        // R9: abort and clear in the same cycle, set wins
        step(1, 0, 0, 1, 2'b00, 0, 0);
        step(1, 1, 1, 1, 2'b00, 1, 1);
        step(0, 0, 0, 1, 2'b00, 0, 0);

        // constrained random traffic
        r = 2'b00;
        for (int n = 0; n < 4000; n++) begin
            if (mst == M_GRANT) begin
                if ($urandom_range(1, 0) == 1) r = 2'b00;
            end else if (mst == M_IDLE && r == 2'b00 && $urandom_range(9, 0) == 0) begin
                r = 2'($urandom_range(3, 1));
            end
            step($urandom_range(3, 0) != 0, $urandom_range(4, 0) == 0,
                 $urandom_range(11, 0) == 0, $urandom_range(1, 0) == 1, r,
                 $urandom_range(15, 0) == 0, $urandom_range(1, 0) == 1);
        end
        for (int i = 0; i < 20; i++) step(0, 1, 0, 1, 2'b00, 0, 0);

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule